// File: doc/BRIEF.md
# One-Third-Rate Polyphase Digital Down Converter

This block turns a stream of real, bandpass-sampled IF samples into complex baseband at one third of the input rate. The target setting is a 180 MS/s sampler watching a 50 MHz wide band centred on 120 MHz, which folds to a carrier at exactly one third of the sample rate. Baseband I/Q leaves the block at 60 MS/s. A 111-tap lowpass prototype is split into three polyphase branches of 37 taps. Because the carrier period is exactly three samples, the carrier value that each branch would multiply by is a constant. The mixer therefore moves behind the branch filters, and both I and Q come from one shared filter bank.

Samples enter one per clock when `samp_en` is high. A commutator deals them to the branches in rotation. When a group of three samples is complete, the three branch sums are combined. I is formed from shifts and adds only. Q uses a single multiply by a fixed-point constant close to √3/2. Outputs are held back until every branch delay line has been filled with real samples.

Top module: `dcv_fs3_ddc`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_i` and `out_q` are 0. The first sample accepted after reset is sample index 0 of a new stream, and the commutator restarts at phase 0.
- R2: Accepted samples are numbered x[0], x[1], …; unaccepted clocks do not count. For each group k, the branch sums are B_b(k) = Σ_{j=0..36} h[3j+b]·x[3k+2−b−3j] for b = 0, 1, 2, where samples before index 0 count as 0. Sample n is stored in branch 2 − (n mod 3).
- R3: The in-phase output of group k is B0 − floor((B1 + B2)/2).
- R4: The quadrature output of group k is floor(((B1 − B2)·113512 + 65536) / 2^17). Here 113512 is √3/2 in Q1.17, and the product is rounded half-up.
- R5: `out_valid` is a one-cycle pulse. It is high in the second clock cycle after the edge that accepts sample 3k+2.
- R6: Groups 0 to 35 produce no output. Every group k ≥ 36 produces exactly one output, in order.
- R7: Clocks with `samp_en` low have no effect. `samp_in` is ignored, the commutator phase holds, and `out_i`/`out_q` keep their last values with `out_valid` low.
- R8: The default prototype is the 111-tap triangle h[m] = SCALE·(min(m, 110−m) + 1), with SCALE = 2000 and 18-bit signed coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Qualifies `samp_in` as the next input sample |
| samp_in | input | 16 | Real IF sample, two's complement |
| out_valid | output | 1 | Pulses once per output baseband sample |
| out_i | output | 41 | In-phase baseband sample, two's complement |
| out_q | output | 41 | Quadrature baseband sample, two's complement |

## Verification
Isolated impulses placed at positions with different residues mod 3 show whether each sample reaches the right branch and tap. A constant input and a tone at one third of the rate, in both cosine and sine phase, separate the I shift-and-add path from the Q constant multiply and its rounding. Full-scale alternating and random streams probe the width of the accumulator and combiner. Streams with random idle gaps, a reset in the middle of a stream, and a run that stops exactly at the fill boundary check the commutator hold, the restart, the output latency and the suppression of early outputs.

// File: rtl/dcv_pkg.sv
package dcv_pkg;

  // Decimation equals the carrier period; the constant-mixer rotation relies on it.
  localparam int DECIM = 3;

  // Default triangular prototype tap m of a taps-long lowpass.
  function automatic int proto_coef(int m, int taps, int scale);
    int d;
    d = (m < taps - 1 - m) ? m : taps - 1 - m;
    return scale * (d + 1);
  endfunction

  // round(sqrt(3)/2 * 2^frac) via integer square root with one guard bit.
  function automatic int root3_half(int frac);
    longint tgt;
    longint lo;
    longint hi;
    longint mid;
    tgt = longint'(3) << (2 * frac);
    lo  = 0;
    hi  = longint'(1) << (frac + 1);
    while (lo < hi) begin
      mid = (lo + hi + 1) >> 1;
      if (mid * mid <= tgt) lo = mid;
      else                  hi = mid - 1;
    end
    return int'((lo + 1) >>> 1);
  endfunction

endpackage

// File: rtl/dcv_commutator.sv
module dcv_commutator #(
  parameter  int NPH  = 3,
  parameter  int FILL = 36,
  localparam int PW   = $clog2(NPH),
  localparam int KW   = $clog2(FILL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_en,
  output logic [PW-1:0] phase,
  output logic          frame_done,
  output logic          frame_ok
);

  logic [PW-1:0] phase_q, phase_d;
  logic [KW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          ok_q, ok_d;
  logic          last_w;

  always_comb begin
    last_w  = samp_en && (phase_q == PW'(NPH - 1));
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (samp_en) phase_d = last_w ? '0 : phase_q + PW'(1);
    if (last_w && (cnt_q != KW'(FILL))) cnt_d = cnt_q + KW'(1);
    done_d  = last_w;
    ok_d    = last_w && (cnt_q == KW'(FILL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      ok_q    <= ok_d;
    end
  end

  assign phase      = phase_q;
  assign frame_done = done_q;
  assign frame_ok   = ok_q;

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < PW'(NPH)) else $error("phase out of range");

  assert_group_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_en && phase_q == PW'(NPH - 1)) |=> (frame_done && phase_q == '0))
    else $error("group close missed");

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> ($stable(phase_q) && !frame_done)) else $error("idle clock moved commutator");

endmodule

// File: rtl/dcv_branch_fir.sv
module dcv_branch_fir #(
  parameter int DW    = 16,
  parameter int CW    = 18,
  parameter int BTAPS = 37,
  parameter int BIDX  = 0,
  parameter int NPH   = 3,
  parameter int TAPS  = 111,
  parameter int SCALE = 2000,
  parameter int AW    = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 calc,
  input  logic signed [DW-1:0] din,
  output logic signed [AW-1:0] acc
);

  logic signed [DW-1:0] line_q [BTAPS];
  logic signed [DW-1:0] line_d [BTAPS];
  logic signed [AW-1:0] coef_w [BTAPS];
  logic signed [AW-1:0] dot;
  logic signed [AW-1:0] acc_q, acc_d;

  // Branch BIDX owns prototype taps BIDX, BIDX+NPH, BIDX+2*NPH, ...
  for (genvar j = 0; j < BTAPS; j++) begin : g_coef
    localparam int M = NPH * j + BIDX;
    localparam logic signed [CW-1:0] CV =
      (M < TAPS) ? CW'(dcv_pkg::proto_coef(M, TAPS, SCALE)) : '0;
    assign coef_w[j] = AW'(CV);
  end

  always_comb begin
    dot = '0;
    for (int j = 0; j < BTAPS; j++) begin
      dot = dot + AW'(line_q[j]) * coef_w[j];
    end
  end

  always_comb begin
    line_d = line_q;
    if (load) begin
      line_d[0] = din;
      for (int j = 1; j < BTAPS; j++) line_d[j] = line_q[j-1];
    end
    acc_d = calc ? dot : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < BTAPS; j++) line_q[j] <= '0;
      acc_q <= '0;
    end else begin
      line_q <= line_d;
      acc_q  <= acc_d;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/dcv_combiner.sv
module dcv_combiner #(
  parameter  int AW  = 40,
  parameter  int KF  = 17,
  localparam int OW  = AW + 1,
  localparam int KW  = KF + 1,
  localparam int PRW = OW + KW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 calc,
  input  logic signed [AW-1:0] b0,
  input  logic signed [AW-1:0] b1,
  input  logic signed [AW-1:0] b2,
  output logic                 vld,
  output logic signed [OW-1:0] i_out,
  output logic signed [OW-1:0] q_out
);

  localparam logic signed [KW-1:0]  KROT     = KW'(dcv_pkg::root3_half(KF));
  localparam logic signed [PRW-1:0] RND_BIAS = PRW'(1) <<< (KF - 1);

  logic signed [OW-1:0]  pair_sum, half, diff, i_d, q_d;
  logic signed [PRW-1:0] prod, rnd;
  logic signed [OW-1:0]  i_q, q_q;
  logic                  vld_q;

  always_comb begin
    // cos terms 1, -1/2, -1/2: arithmetic shift replaces the multiply
    pair_sum = OW'(b1) + OW'(b2);
    half     = pair_sum >>> 1;
    i_d      = OW'(b0) - half;
    // sin terms 0, +k, -k: one constant product, rounded half-up
    diff     = OW'(b1) - OW'(b2);
    prod     = PRW'(diff) * PRW'(KROT);
    rnd      = prod + RND_BIAS;
    q_d      = OW'(rnd >>> KF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      i_q   <= '0;
      q_q   <= '0;
    end else begin
      vld_q <= calc;
      if (calc) begin
        i_q <= i_d;
        q_q <= q_d;
      end
    end
  end

  assign vld   = vld_q;
  assign i_out = i_q;
  assign q_out = q_q;

  assert_q_balanced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (calc && b1 == b2) |=> (q_out == '0)) else $error("Q nonzero for equal branches");

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !calc |=> ($stable(i_out) && $stable(q_out) && !vld)) else $error("output moved without group");

endmodule

// File: rtl/dcv_fs3_ddc.sv
module dcv_fs3_ddc #(
  parameter  int DW    = 16,
  parameter  int CW    = 18,
  parameter  int TAPS  = 111,
  parameter  int SCALE = 2000,
  parameter  int KF    = 17,
  localparam int NPH   = dcv_pkg::DECIM,
  localparam int PW    = $clog2(NPH),
  localparam int BTAPS = (TAPS + NPH - 1) / NPH,
  localparam int AW    = DW + CW + $clog2(BTAPS),
  localparam int OW    = AW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 samp_en,
  input  logic signed [DW-1:0] samp_in,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q
);

  logic [PW-1:0]        phase;
  logic                 frame_done;
  logic                 frame_ok;
  logic [NPH-1:0]       load_w;
  logic signed [AW-1:0] bsum [NPH];
  logic                 bvld_q, bvld_d;

  dcv_commutator #(.NPH(NPH), .FILL(BTAPS - 1)) u_comm (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_en    (samp_en),
    .phase      (phase),
    .frame_done (frame_done),
    .frame_ok   (frame_ok)
  );

  // The last sample of a group feeds branch 0, the first feeds branch NPH-1.
  for (genvar b = 0; b < NPH; b++) begin : g_branch
    assign load_w[b] = samp_en && (phase == PW'(NPH - 1 - b));

    dcv_branch_fir #(
      .DW(DW), .CW(CW), .BTAPS(BTAPS), .BIDX(b),
      .NPH(NPH), .TAPS(TAPS), .SCALE(SCALE), .AW(AW)
    ) u_fir (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_w[b]),
      .calc  (frame_done),
      .din   (samp_in),
      .acc   (bsum[b])
    );
  end

  always_comb bvld_d = frame_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bvld_q <= 1'b0;
    else        bvld_q <= bvld_d;
  end

  dcv_combiner #(.AW(AW), .KF(KF)) u_comb (
    .clk   (clk),
    .rst_n (rst_n),
    .calc  (bvld_q),
    .b0    (bsum[0]),
    .b1    (bsum[1]),
    .b2    (bsum[2]),
    .vld   (out_valid),
    .i_out (out_i),
    .q_out (out_q)
  );

  assert_one_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(load_w) == (samp_en ? 1 : 0)) else $error("sample not routed to exactly one branch");

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> ##1 out_valid) else $error("output latency wrong");

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid) else $error("out_valid longer than one cycle");

endmodule

// File: tb/test_dcv_fs3_ddc.sv
module test_dcv_fs3_ddc;

  localparam int DW    = 16;
  localparam int TAPS  = 111;
  localparam int SCALE = 2000;
  localparam int BT    = 37;
  localparam int FIRST = 36;
  localparam int OW    = 41;
  localparam longint KQ = 113512;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 samp_en = 1'b0;
  logic signed [DW-1:0] samp_in = '0;
  logic                 out_valid;
  logic signed [OW-1:0] out_i, out_q;

  always #10 clk = ~clk;

  dcv_fs3_ddc #(.DW(DW), .TAPS(TAPS), .SCALE(SCALE)) i_dcv_fs3_ddc (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .samp_in(samp_in),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int     checks = 0;
  int     fails  = 0;
  bit     finished = 1'b0;
  longint xs [0:1023];
  int     nx = 0;
  int     nout = 0;
  string  req = "R1";
  longint exp_i [$];
  longint exp_q [$];

  function automatic longint hcoef(int m);
    int d;
    d = (m < TAPS - 1 - m) ? m : TAPS - 1 - m;
    return longint'(SCALE) * longint'(d + 1);
  endfunction

  function automatic longint bsum(int b, int k);
    longint s = 0;
    for (int j = 0; j < BT; j++) begin
      int idx;
      idx = 3 * k + 2 - b - 3 * j;
      if (idx >= 0) s += hcoef(3 * j + b) * xs[idx];
    end
    return s;
  endfunction

  task automatic check(bit ok, string r, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, expv);
    end
  endtask

  task automatic push(longint v);
    samp_en = 1'b1;
    samp_in = DW'(v);
    xs[nx] = v;
    nx++;
    if (nx % 3 == 0 && (nx / 3 - 1) >= FIRST) begin
      int k;
      longint b0, b1, b2;
      k  = nx / 3 - 1;
      b0 = bsum(0, k);
      b1 = bsum(1, k);
      b2 = bsum(2, k);
      exp_i.push_back(b0 - ((b1 + b2) >>> 1));
      exp_q.push_back(((b1 - b2) * KQ + 65536) >>> 17);
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    samp_en = 1'b0;
    for (int c = 0; c < n; c++) begin
      samp_in = DW'($urandom);
      @(negedge clk);
    end
  endtask

  function automatic longint rnd16();
    return longint'($urandom_range(65535)) - 32768;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      nout++;
      if (exp_i.size() == 0) begin
        check(1'b0, "R6", "unexpected output", nout, 0);
      end else begin
        longint ei, eq;
        ei = exp_i.pop_front();
        eq = exp_q.pop_front();
        check(longint'(out_i) == ei, {req, "/R3"}, "out_i", longint'(out_i), ei);
        check(longint'(out_q) == eq, {req, "/R4"}, "out_q", longint'(out_q), eq);
      end
    end
  end

  task automatic do_reset(string r);
    samp_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, r, "out_valid in reset", longint'(out_valid), 0);
    check(out_i == '0, r, "out_i in reset", longint'(out_i), 0);
    check(out_q == '0, r, "out_q in reset", longint'(out_q), 0);
    exp_i.delete();
    exp_q.delete();
    nx = 0;
    nout = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic end_scn(string r, int want);
    idle(6);
    check(exp_i.size() == 0, r, "outputs still pending", exp_i.size(), 0);
    check(nout == want, r, "output count", nout, want);
  endtask

  // R1 R5 R6: nothing before group 36, then one pulse at the expected cycle
  task automatic t_fill();
    req = "R6";
    do_reset("R1");
    for (int n = 0; n < 110; n++) push(longint'(n * 7 - 300));
    check(nout == 0, "R6", "outputs before group 36", nout, 0);
    push(1234);
    samp_en = 1'b0;
    check(out_valid == 1'b0, "R5", "valid after accept edge", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R5", "valid one cycle later", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R5", "valid second cycle", longint'(out_valid), 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R5", "valid pulse width", longint'(out_valid), 0);
    end_scn("R6", 1);
  endtask

  // R2 R8: impulses at residues 0, 1, 2 hit distinct branches and taps
  task automatic t_impulse();
    req = "R2";
    do_reset("R1");
    for (int n = 0; n < 270; n++) begin
      longint v = 0;
      if (n == 120) v = 1000;
      if (n == 160) v = -2000;
      if (n == 203) v = 32767;
      push(v);
    end
    end_scn("R2", 90 - FIRST);
  endtask

  // R3 R8: constant input
  task automatic t_dc();
    req = "R3";
    do_reset("R1");
    for (int n = 0; n < 150; n++) push(12345);
    end_scn("R3", 50 - FIRST);
  endtask

  // R3 R4: carrier tones in cosine and sine phase
  task automatic t_tone();
    longint cpat [3] = '{20000, -10000, -10000};
    longint spat [3] = '{0, 17320, -17320};
    req = "R4";
    do_reset("R1");
    for (int n = 0; n < 150; n++) push(cpat[n % 3]);
    for (int n = 0; n < 150; n++) push(spat[n % 3]);
    end_scn("R4", 100 - FIRST);
  endtask

  // R3 R4: full-scale alternating extremes
  task automatic t_extreme();
    req = "R3";
    do_reset("R1");
    for (int n = 0; n < 180; n++) push((n % 2 == 0) ? -32768 : 32767);
    for (int n = 0; n < 120; n++) push(((n / 3) % 2 == 0) ? -32768 : 32767);
    end_scn("R3", 100 - FIRST);
  endtask

  // R2 R3 R4: random stream
  task automatic t_random();
    req = "R2";
    do_reset("R1");
    for (int n = 0; n < 300; n++) push(rnd16());
    end_scn("R2", 100 - FIRST);
  endtask

  // R7: idle gaps with garbage on samp_in, then a long idle stretch
  task automatic t_gaps();
    longint li, lq;
    req = "R7";
    do_reset("R1");
    for (int n = 0; n < 240; n++) begin
      push(rnd16());
      if ($urandom_range(3) == 0) idle($urandom_range(3) + 1);
    end
    end_scn("R7", 80 - FIRST);
    li = longint'(out_i);
    lq = longint'(out_q);
    idle(20);
    check(longint'(out_i) == li, "R7", "out_i held while idle", longint'(out_i), li);
    check(longint'(out_q) == lq, "R7", "out_q held while idle", longint'(out_q), lq);
    check(nout == 80 - FIRST, "R7", "no output while idle", nout, 80 - FIRST);
  endtask

  // R1: reset in the middle of a group restarts the commutator
  task automatic t_midreset();
    req = "R1";
    do_reset("R1");
    for (int n = 0; n < 50; n++) push(rnd16());
    do_reset("R1");
    for (int n = 0; n < 150; n++) push(rnd16());
    end_scn("R1", 50 - FIRST);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_fill();
    t_impulse();
    t_dc();
    t_tone();
    t_extreme();
    t_random();
    t_gaps();
    t_midreset();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule